// File: doc/BRIEF.md
# Result Holding Buffer with Register-File Spill

This block sits between the result buses of the execution units and a physical register file. Every produced result goes into a small buffer that is ordered by age. The result is tagged with its physical register number. Most values are read within a few cycles of being produced, so most operand reads are served from the buffer, and the register file is written only when a value outlives its slot. When the buffer is full, a new insert pushes out the oldest slot. If that slot still holds a live value, the value is written into the register file.

A bitmap holds one bit per physical register and records whether the current value is in the buffer (1) or in the register file (0). A read checks that bit first and goes straight to the right store, so both paths have the same latency. Entries can be killed out of order when their register is released. A misprediction flush empties the buffer at once. An exception starts a drain that copies every live entry, oldest first, into the register file, one per cycle, and holds the block busy while it does so. The register file is a behavioural array inside the block. Three counters report buffer hits, register-file reads and spills.

Top module: `value_aging_buffer`

## Requirements
- R1: After reset the buffer is empty, every location bit is 0, `busy` and `rd_valid` are 0, and all three counters read 0.
- R2: The buffer holds `DEPTH` slots, and `DEPTH` is a power of two. Inserts into a buffer that is not full write nothing to the register file.
- R3: A read accepted in one cycle gives `rd_valid`=1 in the next cycle. If the register has a valid buffer entry, the read returns `rd_hit`=1 and the data of the youngest matching entry. Otherwise it returns `rd_hit`=0 and the register-file contents.
- R4: An insert into a full buffer removes the oldest slot. If that slot is valid, its data is written to the register file at its tag. If the slot is invalid, nothing is written.
- R5: `evict_cnt` increases by exactly one for each spill that writes the register file, and it does not change for any other event.
- R6: A read of the register that is being inserted in the same cycle returns the new data with `rd_hit`=1.
- R7: A register's location bit is 1 exactly while a valid buffer entry holds that register. A read of a register with no valid entry goes to the register file.
- R8: `free_en` clears the valid bit of every entry tagged `free_tag`, and later reads of that register go to the register file. A free and an insert of the same register in one cycle leave the new value valid in the buffer.
- R9: `flush` empties the buffer without writing the register file. An insert in the same cycle is dropped. A read in the same cycle is served from the contents before the flush.
- R10: `exc` starts a drain. `busy` is high for N+1 cycles, where N is the number of occupied slots including invalid ones. Valid entries are copied oldest first, and the buffer is then empty with every location bit at 0. Writes, reads, frees and flushes in the `exc` cycle or while `busy` is high have no effect, and `rd_valid` stays 0.
- R11: Each accepted read adds one to `hit_cnt` if it was served from the buffer, or to `miss_cnt` if it was served from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Insert a produced result |
| wr_tag | input | $clog2(NUM_PREGS) | Physical register of the result |
| wr_data | input | DATA_W | Result value |
| rd_en | input | 1 | Operand read request |
| rd_tag | input | $clog2(NUM_PREGS) | Physical register to read |
| free_en | input | 1 | Release a physical register |
| free_tag | input | $clog2(NUM_PREGS) | Register being released |
| flush | input | 1 | Misprediction: discard buffer contents |
| exc | input | 1 | Exception: drain buffer to the register file |
| rd_valid | output | 1 | Read result valid |
| rd_hit | output | 1 | Read was served from the buffer |
| rd_data | output | DATA_W | Read data |
| busy | output | 1 | Drain in progress |
| hit_cnt | output | CNT_W | Reads served from the buffer |
| miss_cnt | output | CNT_W | Reads served from the register file |
| evict_cnt | output | CNT_W | Spills written into the register file |

## Verification
The bench uses a small configuration with 16 registers and 4 slots. It first sweeps every register tag through insert-with-same-cycle-read. This fills the buffer, overflows it twelve times, and shows that the bypass works and that spilled values land at the right address. A read pass over all tags then separates the values still held in the buffer from those in the register file. Repeated writes to one tag check youngest-match priority. Frees followed by age-out check that dead slots spill nothing. A flush with a colliding insert shows that the insert is dropped. Drains are started at full, partial and zero occupancy, and at full occupancy with a hole. Their busy lengths and post-drain reads tell the occupancy count apart from the valid count, and show that inputs presented while busy are ignored.

// File: rtl/vab_pkg.sv
package vab_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } vab_state_e;
endpackage

// File: rtl/vab_regfile.sv
// Behavioural physical register file: one write port, one combinational read port.
module vab_regfile #(
  parameter int NUM_PREGS = 64,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = $clog2(NUM_PREGS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TAG_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAG_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_PREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vab_locmap.sv
// One bit per physical register: 1 while its live value sits in the buffer.
module vab_locmap #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W     = $clog2(NUM_PREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clra_en,
  input  logic [TAG_W-1:0] clra_tag,
  input  logic             clrb_en,
  input  logic [TAG_W-1:0] clrb_tag,
  input  logic [TAG_W-1:0] q_tag,
  output logic             q_bit
);
  logic [NUM_PREGS-1:0] loc;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      loc <= '0;
    end else begin
      if (clra_en) loc[clra_tag] <= 1'b0;
      if (clrb_en) loc[clrb_tag] <= 1'b0;
      if (set_en)  loc[set_tag]  <= 1'b1;   // insert wins over same-cycle clears
    end
  end

  assign q_bit = loc[q_tag];
endmodule

// File: rtl/vab_match.sv
// Tag search across all slots, walking oldest to youngest so the youngest match wins.
module vab_match #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]  head,
  input  logic [DEPTH-1:0]  vld,
  input  logic [TAG_W-1:0]  tags  [DEPTH],
  input  logic [DATA_W-1:0] datas [DEPTH],
  input  logic [TAG_W-1:0]  q_tag,
  output logic              hit,
  output logic [DATA_W-1:0] data
);
  logic [PTR_W-1:0] idx;

  always_comb begin
    hit  = 1'b0;
    data = '0;
    idx  = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (vld[idx] && tags[idx] == q_tag) begin
        hit  = 1'b1;
        data = datas[idx];
      end
    end
  end
endmodule

// File: rtl/value_aging_buffer.sv
module value_aging_buffer #(
  parameter int NUM_PREGS = 64,
  parameter int DEPTH     = 16,   // power of two, at least 2
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_PREGS)-1:0] wr_tag,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [$clog2(NUM_PREGS)-1:0] rd_tag,
  input  logic                         free_en,
  input  logic [$clog2(NUM_PREGS)-1:0] free_tag,
  input  logic                         flush,
  input  logic                         exc,
  output logic                         rd_valid,
  output logic                         rd_hit,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         busy,
  output logic [CNT_W-1:0]             hit_cnt,
  output logic [CNT_W-1:0]             miss_cnt,
  output logic [CNT_W-1:0]             evict_cnt
);
  import vab_pkg::*;

  localparam int TAG_W  = $clog2(NUM_PREGS);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH + 1);

  vab_state_e state;
  logic [PTR_W-1:0]  head, tail, dptr;
  logic [FILL_W-1:0] fill, drem;
  logic [DEPTH-1:0]  e_vld;
  logic [TAG_W-1:0]  e_tag  [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];

  logic act, ins, full, free_go, flush_go, rd_go, bypass;
  logic head_live, spill_wr, others, drain_wr, drain_done;
  logic loc_q, m_hit, from_buf;
  logic rf_we;
  logic [TAG_W-1:0]  head_tag, rf_waddr;
  logic [DATA_W-1:0] rf_wdata, rf_rdata, m_data;
  logic [DEPTH-1:0]  oth;

  assign busy       = (state == ST_DRAIN);
  assign act        = !busy && !exc;
  assign flush_go   = act && flush;
  assign ins        = act && wr_en && !flush;
  assign free_go    = act && free_en && !flush;
  assign rd_go      = act && rd_en;
  assign full       = (fill == FILL_W'(DEPTH));
  assign head_tag   = e_tag[head];
  assign head_live  = e_vld[head] && !(free_go && free_tag == head_tag);
  assign spill_wr   = ins && full && head_live;
  assign drain_done = busy && (drem == '0);
  assign drain_wr   = busy && (drem != '0) && e_vld[dptr];

  // Other live copies of the oldest slot's register keep its location bit set.
  for (genvar i = 0; i < DEPTH; i++) begin : g_oth
    assign oth[i] = e_vld[i] && (e_tag[i] == head_tag) && (PTR_W'(i) != head);
  end
  assign others = |oth;

  assign rf_we    = spill_wr || drain_wr;
  assign rf_waddr = spill_wr ? head_tag : e_tag[dptr];
  assign rf_wdata = spill_wr ? e_data[head] : e_data[dptr];

  vab_regfile #(.NUM_PREGS(NUM_PREGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rd_tag), .rdata(rf_rdata)
  );

  vab_locmap #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_loc (
    .clk(clk), .rst(rst), .clr_all(flush_go || drain_done),
    .set_en(ins), .set_tag(wr_tag),
    .clra_en(free_go), .clra_tag(free_tag),
    .clrb_en(spill_wr && !others), .clrb_tag(head_tag),
    .q_tag(rd_tag), .q_bit(loc_q)
  );

  vab_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_match (
    .head(head), .vld(e_vld), .tags(e_tag), .datas(e_data),
    .q_tag(rd_tag), .hit(m_hit), .data(m_data)
  );

  assign bypass   = ins && (wr_tag == rd_tag);
  assign from_buf = bypass || (loc_q && m_hit);

  // Slot payload: written only at the tail, no reset.
  always_ff @(posedge clk) begin
    if (ins) begin
      e_tag[tail]  <= wr_tag;
      e_data[tail] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      head      <= '0;
      tail      <= '0;
      dptr      <= '0;
      fill      <= '0;
      drem      <= '0;
      e_vld     <= '0;
      rd_valid  <= 1'b0;
      rd_hit    <= 1'b0;
      rd_data   <= '0;
      hit_cnt   <= '0;
      miss_cnt  <= '0;
      evict_cnt <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        rd_hit  <= from_buf;
        rd_data <= bypass ? wr_data : (from_buf ? m_data : rf_rdata);
        if (from_buf) hit_cnt  <= hit_cnt + 1'b1;
        else          miss_cnt <= miss_cnt + 1'b1;
      end
      if (busy) begin
        if (drem != '0) begin
          dptr <= dptr + 1'b1;
          drem <= drem - 1'b1;
        end else begin
          e_vld <= '0;
          head  <= '0;
          tail  <= '0;
          fill  <= '0;
          state <= ST_RUN;
        end
      end else if (exc) begin
        state <= ST_DRAIN;
        dptr  <= head;
        drem  <= fill;
      end else if (flush) begin
        e_vld <= '0;
        head  <= '0;
        tail  <= '0;
        fill  <= '0;
      end else begin
        if (free_go) begin
          for (int i = 0; i < DEPTH; i++) begin
            if (e_tag[i] == free_tag) e_vld[i] <= 1'b0;
          end
        end
        if (ins) begin
          e_vld[tail] <= 1'b1;
          tail        <= tail + 1'b1;
          if (full) head <= head + 1'b1;
          else      fill <= fill + 1'b1;
          if (spill_wr) evict_cnt <= evict_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vab_checker.sv
module vab_checker #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 32,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              exc,
  input logic              flush_go,
  input logic              rd_go,
  input logic              bypass,
  input logic              loc_q,
  input logic              m_hit,
  input logic              rf_we,
  input logic              rd_valid,
  input logic [FILL_W-1:0] fill,
  input logic [CNT_W-1:0]  evict_cnt
);
  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(DEPTH)); // R2

  AST_SPILL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (rf_we && !busy) |-> (fill == FILL_W'(DEPTH))); // R4

  AST_EVICT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (evict_cnt == $past(evict_cnt) || evict_cnt == CNT_W'($past(evict_cnt) + 1'b1))); // R5

  AST_LOC_AGREES: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !bypass) |-> (loc_q == m_hit)); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_go |=> (fill == '0)); // R9

  AST_DRAIN_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(exc)); // R10

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_valid); // R10
endmodule

bind value_aging_buffer vab_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .exc(exc), .flush_go(flush_go),
  .rd_go(rd_go), .bypass(bypass), .loc_q(loc_q), .m_hit(m_hit),
  .rf_we(rf_we), .rd_valid(rd_valid), .fill(fill), .evict_cnt(evict_cnt)
);

// File: tb/value_aging_buffer_tb.sv
`timescale 1ns/1ps
module value_aging_buffer_tb_top;
  localparam int NP = 16;
  localparam int DP = 4;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int TW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, free_en = 0, flush = 0, exc = 0;
  logic [TW-1:0] wr_tag = '0, rd_tag = '0, free_tag = '0;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid, rd_hit, busy;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] hit_cnt, miss_cnt, evict_cnt;

  always #5 clk = ~clk;

  value_aging_buffer #(.NUM_PREGS(NP), .DEPTH(DP), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data),
    .rd_en(rd_en), .rd_tag(rd_tag), .free_en(free_en), .free_tag(free_tag),
    .flush(flush), .exc(exc), .rd_valid(rd_valid), .rd_hit(rd_hit),
    .rd_data(rd_data), .busy(busy), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
    .evict_cnt(evict_cnt)
  );

  int checks = 0, failures = 0;
  // Reference model: slot 0 is oldest.
  int q_tag [DP];
  int q_dat [DP];
  bit q_vld [DP];
  int q_n = 0;
  int rf_m [NP];
  bit rf_k [NP];
  int e_hit = 0, e_miss = 0, e_evict = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int dval(int t);
    return 'h100 + t * 7;
  endfunction

  function automatic void m_push(int t, int d);
    if (q_n == DP) begin
      if (q_vld[0]) begin
        rf_m[q_tag[0]] = q_dat[0];
        rf_k[q_tag[0]] = 1'b1;
        e_evict++;
      end
      for (int k = 0; k < DP - 1; k++) begin
        q_tag[k] = q_tag[k+1]; q_dat[k] = q_dat[k+1]; q_vld[k] = q_vld[k+1];
      end
      q_n--;
    end
    q_tag[q_n] = t; q_dat[q_n] = d; q_vld[q_n] = 1'b1;
    q_n++;
  endfunction

  task automatic step(string req, bit we, int wt, int wd, bit re, int rt,
                      bit fe, int ft, bit fl);
    bit eh = 0, known = 0;
    int ed = 0;
    wr_en = we; wr_tag = TW'(wt); wr_data = DW'(wd);
    rd_en = re; rd_tag = TW'(rt);
    free_en = fe; free_tag = TW'(ft); flush = fl;
    if (re) begin
      if (we && !fl && wt == rt) begin
        eh = 1; ed = wd;
      end else begin
        for (int k = 0; k < q_n; k++) begin
          if (q_vld[k] && q_tag[k] == rt) begin eh = 1; ed = q_dat[k]; end
        end
      end
      if (!eh) begin ed = rf_m[rt]; known = rf_k[rt]; end
      if (eh) e_hit++; else e_miss++;
    end
    if (fl) begin
      q_n = 0;
      for (int k = 0; k < DP; k++) q_vld[k] = 0;
    end else begin
      if (fe) for (int k = 0; k < q_n; k++) if (q_tag[k] == ft) q_vld[k] = 0;
      if (we) m_push(wt, wd);
    end
    @(posedge clk); @(negedge clk);
    chk({req, " rd_valid"}, rd_valid, re);
    if (re) begin
      chk({req, " rd_hit"}, rd_hit, eh);
      if (eh || known) chk({req, " rd_data"}, rd_data, DW'(ed));
    end
    chk("R5 evict_cnt", evict_cnt, e_evict);
    chk("R11 hit_cnt", hit_cnt, e_hit);
    chk("R11 miss_cnt", miss_cnt, e_miss);
    wr_en = 0; rd_en = 0; free_en = 0; flush = 0;
  endtask

  task automatic drain_test(string req);
    int exp_len = q_n + 1;
    int n = 0;
    for (int k = 0; k < q_n; k++) begin
      if (q_vld[k]) begin rf_m[q_tag[k]] = q_dat[k]; rf_k[q_tag[k]] = 1; end
      q_vld[k] = 0;
    end
    q_n = 0;
    exc = 1;
    @(posedge clk); @(negedge clk);
    exc = 0;
    // Inputs presented while busy must be ignored (R10).
    wr_en = 1; wr_tag = TW'(2); wr_data = 16'hBEEF;
    rd_en = 1; rd_tag = TW'(2); free_en = 1; free_tag = TW'(9);
    while (busy && n < 50) begin
      n++;
      chk({req, " rd_valid low while busy"}, rd_valid, 0);
      @(posedge clk); @(negedge clk);
    end
    wr_en = 0; rd_en = 0; free_en = 0;
    chk({req, " busy length"}, n, exp_len);
    chk("R5 evict_cnt after drain", evict_cnt, e_evict);
    chk("R11 hit_cnt after drain", hit_cnt, e_hit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < NP; t++) begin rf_m[t] = 0; rf_k[t] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 hit_cnt", hit_cnt, 0);
    chk("R1 miss_cnt", miss_cnt, 0);
    chk("R1 evict_cnt", evict_cnt, 0);
    rst = 0;
    @(negedge clk);
    step("R1 empty read", 0, 0, 0, 1, 6, 0, 0, 0);

    // R6/R4/R2: insert every tag with a same-cycle read of it
    for (int t = 0; t < NP; t++) begin
      step("R6 bypass", 1, t, dval(t), 1, t, 0, 0, 0);
      if (t == DP - 1) chk("R2 no spill before full", evict_cnt, 0);
    end
    chk("R4 spill count after sweep", evict_cnt, NP - DP);

    // R3/R7: read every tag, buffer vs register file
    for (int t = 0; t < NP; t++) step("R3 sweep read", 0, 0, 0, 1, t, 0, 0, 0);

    // R9: flush with colliding insert and read
    step("R9 flush", 1, 3, 'h777, 1, 14, 0, 0, 1);
    step("R9 dropped insert", 0, 0, 0, 1, 3, 0, 0, 0);
    step("R7 after flush", 0, 0, 0, 1, 14, 0, 0, 0);

    // R3: youngest of duplicates wins
    step("R3 dup a", 1, 7, 'hA1, 0, 0, 0, 0, 0);
    step("R3 dup b", 1, 7, 'hB2, 0, 0, 0, 0, 0);
    step("R3 youngest", 0, 0, 0, 1, 7, 0, 0, 0);

    // R8: free then read, dead slots spill nothing
    step("R8 free", 0, 0, 0, 0, 0, 1, 7, 0);
    step("R8 read freed", 0, 0, 0, 1, 7, 0, 0, 0);
    step("R8 fill", 1, 8, 'h88, 0, 0, 0, 0, 0);
    step("R8 fill", 1, 9, 'h99, 0, 0, 0, 0, 0);
    step("R4 age out invalid", 1, 10, 'hAA, 0, 0, 0, 0, 0);
    step("R4 age out invalid", 1, 11, 'hBB, 0, 0, 0, 0, 0);
    step("R4 spill valid", 1, 12, 'hCC, 1, 8, 0, 0, 0);
    step("R4 spilled read", 0, 0, 0, 1, 8, 0, 0, 0);
    step("R8 free and insert same tag", 1, 11, 'hDD, 0, 0, 1, 11, 0);
    step("R8 reinsert survives", 0, 0, 0, 1, 11, 0, 0, 0);

    // R10: drain at full occupancy with a hole
    step("R8 make hole", 0, 0, 0, 0, 0, 1, 10, 0);
    drain_test("R10 full");
    for (int t = 8; t < 13; t++) step("R10 post drain", 0, 0, 0, 1, t, 0, 0, 0);
    step("R10 ignored write", 0, 0, 0, 1, 2, 0, 0, 0);

    // R10: partial and empty drains
    step("R2 part", 1, 1, 'h11, 0, 0, 0, 0, 0);
    step("R2 part", 1, 2, 'h22, 0, 0, 0, 0, 0);
    drain_test("R10 partial");
    step("R10 post partial", 0, 0, 0, 1, 1, 0, 0, 0);
    step("R10 post partial", 0, 0, 0, 1, 2, 0, 0, 0);
    drain_test("R10 empty");
    step("R10 resume insert", 1, 4, 'h44, 1, 4, 0, 0, 0);
    step("R3 resume read", 0, 0, 0, 1, 4, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule